// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is a memory that answers on a two-wire I2C bus as a target device. It holds up to 2048 bytes in a plain register file. Both bus lines arrive as open-drain inputs and are sampled by the system clock. The only bus output is an active-high pull-down enable for SDA. The block recognises START, repeated START and STOP and matches a four-bit device-type code in the first byte after a START. It then either takes a byte address and at most one data byte, or sends bytes from the array.

A persistent address counter always points one past the byte last touched. A read addressed to the device with no preceding address therefore continues where the previous access ended. A write that stops after its address byte (a "dummy" write) only moves the counter, which gives a random read when a repeated START and a read-addressed device byte follow it. Reads continue for as long as the bus master acknowledges. The counter wraps to zero above the top address, which is set by the `ADDR_W` parameter (8 to 11 bits).

A separate preload port writes the array directly, so a test can fill it without using the bus. There is no streaming data path, so the preload port is a plain write strobe with no back-pressure. A write on the preload port takes priority over a bus write in the same cycle.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0) and the address counter is 0, so the first read with no address returns byte 0.
- R2: The first byte after a START is acknowledged (SDA held low for its ninth clock) only if its bits [7:4] equal `DEV_ID` (default 4'b1010). On a mismatch the block releases SDA and acknowledges nothing until the next START.
- R3: With bit 0 of that byte at 0 (write), the next byte is the low 8 bits of the address. Bits [3:1] of the device byte supply address bits 10:8, truncated to `ADDR_W`. The block acknowledges the address byte and one data byte, stores the data byte, and sets the counter to that address plus one. Any further data byte in the same transfer is not acknowledged.
- R4: A write transfer ended by STOP or a repeated START after the address byte stores nothing and leaves the counter equal to that address.
- R5: A START or STOP returns the block from any state to its start of frame (START) or to idle (STOP), and SDA is released in the next cycle.
- R6: With bit 0 of the device byte at 1 (read), the block acknowledges and then sends the byte at the counter, MSB first, and the counter advances by one. Bits [3:1] are ignored on a read.
- R7: A dummy write to address A, followed by a repeated START and a read, returns the byte at A.
- R8: If the master acknowledges a byte it has read, the next byte in address order follows. If it does not, the block releases SDA and waits for START or STOP, and a later read continues after the last byte sent.
- R9: Above address 2^ADDR_W−1 the counter wraps to 0, both within a sequential read and for a read that follows an access to the top address.
- R10: SDA is driven only in acknowledge bits and transmitted data bits, and `sda_oe` changes only while SCL is low.
- R11: A pulse on `pre_we` stores `pre_data` at `pre_addr`, and later bus reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | ADDR_W | Preload byte address |
| pre_data | input | 8 | Preload byte |

## Verification
The bench attacks the address counter at its edges:
- A dummy write that STOP ends, where a design that committed the pointer only with the data byte would return the wrong byte on the next read.
- A sequential read across address 2047, where a wrong counter width or an added limit would fail to return to byte 0.
- A read that follows a write to the top address, which must also wrap to byte 0.

It also sends a device byte with the wrong type code, a second data byte in one write, and a STOP in the middle of a byte. A design with a loose match, an added page buffer or a state machine that hangs would show up as a wrong acknowledge or a wrong byte read afterwards. A line monitor flags any change of the pull-down while SCL is high.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_ADR, ST_ACK_ADR,
    ST_DAT, ST_ACK_DAT, ST_TX, ST_MACK, ST_HOLD
  } tgt_state_e;

  typedef struct packed {
    logic scl;       // synchronised SCL level
    logic sda;       // synchronised SDA level
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } line_ev_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output line_ev_t ev
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_q, sda_q;
  logic         scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[MSB-1:0], scl_i};
      sda_q <= {sda_q[MSB-1:0], sda_i};
      scl_d <= scl_q[MSB];
      sda_d <= sda_q[MSB];
    end
  end

  always_comb begin
    ev.scl      = scl_q[MSB];
    ev.sda      = sda_q[MSB];
    ev.scl_rise = scl_q[MSB] & ~scl_d;
    ev.scl_fall = ~scl_q[MSB] & scl_d;
    ev.start    = scl_d & scl_q[MSB] & sda_d & ~sda_q[MSB];
    ev.stop     = scl_d & scl_q[MSB] & ~sda_d & sda_q[MSB];
  end
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_data,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pre_we)      mem[pre_addr] <= pre_data;
    else if (bus_we) mem[bus_addr] <= bus_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_mem_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter logic [3:0]  DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_ev_t          ev,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sda_oe
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [3:0]        BYTE_BITS = 4'd8;

  tgt_state_e        state;
  logic [3:0]        cnt;
  logic [7:0]        shreg, tx, adr_lo;
  logic [2:0]        page;
  logic              rw, mack;
  logic [10:0]       wide_addr;
  logic [ADDR_W-1:0] tgt_addr;
  logic              receiving, byte_done;

  assign wide_addr = {page, adr_lo};
  assign tgt_addr  = wide_addr[ADDR_W-1:0];
  assign receiving = (state == ST_DEV) || (state == ST_ADR) || (state == ST_DAT);
  assign byte_done = ev.scl_fall && (cnt == BYTE_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      adr_lo  <= '0;
      page    <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (ev.start) begin
        state  <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (ev.stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        if (receiving && ev.scl_rise && cnt != BYTE_BITS) begin
          shreg <= {shreg[6:0], ev.sda};
          cnt   <= cnt + 4'd1;
        end
        case (state)
          ST_DEV: if (byte_done) begin
            cnt <= '0;
            if (shreg[7:4] == DEV_ID) begin
              page   <= shreg[3:1];
              rw     <= shreg[0];
              sda_oe <= 1'b1;
              state  <= ST_ACK_DEV;
            end else begin
              state  <= ST_IDLE;
            end
          end
          ST_ACK_DEV: if (ev.scl_fall) begin
            if (rw) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              cnt    <= 4'd1;
              ptr    <= ptr + ONE;
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_ADR;
            end
          end
          ST_ADR: if (byte_done) begin
            adr_lo <= shreg;
            cnt    <= '0;
            sda_oe <= 1'b1;
            state  <= ST_ACK_ADR;
          end
          ST_ACK_ADR: if (ev.scl_fall) begin
            sda_oe <= 1'b0;
            ptr    <= tgt_addr;
            cnt    <= '0;
            state  <= ST_DAT;
          end
          ST_DAT: if (byte_done) begin
            wr_en   <= 1'b1;
            wr_addr <= tgt_addr;
            wr_data <= shreg;
            ptr     <= tgt_addr + ONE;
            cnt     <= '0;
            sda_oe  <= 1'b1;
            state   <= ST_ACK_DAT;
          end
          ST_ACK_DAT: if (ev.scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_HOLD;
          end
          ST_TX: if (ev.scl_fall) begin
            if (cnt == BYTE_BITS) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              sda_oe <= ~tx[6];
              tx     <= {tx[6:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end
          end
          ST_MACK: begin
            if (ev.scl_rise) mack <= ~ev.sda;
            if (ev.scl_fall) begin
              if (mack) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                cnt    <= 4'd1;
                ptr    <= ptr + ONE;
                state  <= ST_TX;
              end else begin
                state  <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int         ADDR_W = 11,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_data
);
  line_ev_t          ev;
  logic [ADDR_W-1:0] ptr, wr_addr;
  logic [7:0]        rd_data, wr_data;
  logic              wr_en;

  i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
  );

  i2c_tgt_fsm #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev(ev), .rd_data(rd_data), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .bus_we(wr_en), .bus_addr(wr_addr), .bus_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data)
  );
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start,
  input logic stop,
  input logic wr_en,
  input logic sda_oe
);
  a_r1_reset_release: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  a_r5_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sda_oe);

  a_r5_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe);

  a_r5_no_both_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && stop));

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r10_release_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !$past(start) && !$past(stop)) |-> !scl_s);

  a_r3_store_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_s);
endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(ev.scl), .start(ev.start),
  .stop(ev.stop), .wr_en(wr_en), .sda_oe(sda_oe)
);

// File: tb/sim_i2c_mem_target.sv
module sim_i2c_mem_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 8;
  localparam int AW = 11;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          m_scl = 1'b1, m_sda = 1'b1;
  logic          sda_oe, sda_line, prev_oe = 1'b0;
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0]    pre_data = '0;
  logic [7:0]    model [2**AW];
  int            checks = 0, errors = 0, viol = 0;

  assign sda_line = m_sda & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_target #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  // R10 line monitor: pull-down must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && m_scl && (sda_oe !== prev_oe)) viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq();
    m_sda = 1'b0; waitq(); m_scl = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq(); m_scl = 1'b1; waitq();
    m_sda = 1'b1; waitq(); waitq();
  endtask

  task automatic bus_bit(input logic b, output logic r);
    m_sda = b; waitq(); m_scl = 1'b1; waitq();
    r = sda_line; waitq(); m_scl = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~ack, r);
  endtask

  task automatic cur_read(string req, logic [7:0] exp);
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hA1, a);
    check(req, "read address ack", a, 1);
    recv_byte(1'b0, d);
    bus_stop();
    check(req, "current read data", d, exp);
  endtask

  task automatic point_to(string req, logic [10:0] ad);
    logic a;
    bus_start();
    send_byte({4'hA, ad[10:8], 1'b0}, a);
    check(req, "write address ack", a, 1);
    send_byte(ad[7:0], a);
    check(req, "byte address ack", a, 1);
  endtask

  task automatic rand_read(string req, logic [10:0] ad, int n);
    logic a; logic [7:0] d;
    point_to(req, ad);
    bus_start();
    send_byte(8'hA1, a);
    check(req, "repeated start ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(req, "sequential data", d, model[AW'(ad + 11'(i))]);
    end
    check(req, "released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1", "sda_oe after reset", sda_oe, 0);
    cur_read("R1", model[0]);
  endtask

  task automatic t_bad_type();
    logic a;
    bus_start();
    send_byte(8'h90, a);
    check("R2", "foreign device byte ack", a, 0);
    send_byte(8'h00, a);
    check("R2", "following byte ack", a, 0);
    bus_stop();
    cur_read("R2", model[1]);
  endtask

  task automatic t_write();
    logic a;
    point_to("R3", 11'h2A5);
    send_byte(8'h3C, a);
    check("R3", "data ack", a, 1);
    model[11'h2A5] = 8'h3C;
    send_byte(8'h77, a);
    check("R3", "second data byte ack", a, 0);
    bus_stop();
    cur_read("R3", model[11'h2A6]);
    rand_read("R7", 11'h2A5, 1);
  endtask

  task automatic t_dummy();
    point_to("R4", 11'h055);
    bus_stop();
    cur_read("R4", model[11'h055]);
  endtask

  task automatic t_seq();
    rand_read("R8", 11'h100, 4);
    cur_read("R8", model[11'h104]);
    cur_read("R6", model[11'h105]);
  endtask

  task automatic t_wrap();
    logic a;
    rand_read("R9", 11'h7FE, 3);
    point_to("R9", 11'h7FF);
    send_byte(8'h11, a);
    check("R9", "top data ack", a, 1);
    model[11'h7FF] = 8'h11;
    bus_stop();
    cur_read("R9", model[0]);
  endtask

  task automatic t_abort();
    logic r;
    bus_start();
    bus_bit(1'b1, r); bus_bit(1'b0, r); bus_bit(1'b1, r); bus_bit(1'b0, r);
    bus_stop();
    check("R5", "sda_oe after mid-byte stop", sda_oe, 0);
    cur_read("R5", model[1]);
    bus_start();
    bus_bit(1'b1, r); bus_bit(1'b0, r); bus_bit(1'b0, r);
    cur_read("R5", model[2]);
  endtask

  task automatic t_preload();
    @(negedge clk);
    pre_we = 1'b1; pre_addr = 11'h333; pre_data = 8'hE7;
    @(negedge clk);
    pre_we = 1'b0;
    model[11'h333] = 8'hE7;
    rand_read("R11", 11'h333, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 2**AW; a++) begin
      model[a] = 8'(a * 13 + 5) ^ 8'(a >> 3);
      pre_we = 1'b1; pre_addr = AW'(a); pre_data = model[a];
      @(negedge clk);
    end
    pre_we = 1'b0;
    waitq();
    t_reset();
    t_bad_type();
    t_write();
    t_dummy();
    t_seq();
    t_wrap();
    t_abort();
    t_preload();
    check("R10", "pull-down changes while SCL high", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule